// File: doc/BRIEF.md
# Triangular-Carrier PWM Duty Counter

This block produces a symmetric triangular carrier and a duty event derived from it. A carrier counter rises from zero to a programmed period value and falls back to zero. At the bottom of each triangle it emits a one-cycle period pulse. A second counter, the duty tracker, moves in lockstep with the carrier. It loads a duty value at the start of each triangle and steps opposite to the carrier, so its count is always the latched duty minus the carrier count. It emits a one-cycle duty pulse each time it lands on one, which happens once while the carrier rises and once while it falls.

The period and duty inputs are sampled only at channel start and at each carrier bottom, so software may change them at any time without tearing the current triangle. A slope flag tells downstream logic (for example dead-time insertion and pin drive, which live elsewhere) on which half of the carrier the latest duty pulse fell.

Top module: `tri_pwm_duty`

## Requirements
- R1: On synchronous active-high reset, every output (dutyPulse, slopeDown, periodPulse, dirDown) is 0.
- R2: A start edge seen while the channel is idle and runEn is 1 sets the carrier to 0, rising. Counting the start edge as edge 0, dirDown is 1 after edges P through 2P-1 of each 2P-edge triangle and 0 otherwise, where P is the latched period.
- R3: periodPulse is high for exactly one cycle, after every edge 2P, 4P, ... counted from the start edge (the carrier bottom). A period input of 0 is treated as 1.
- R4: periodIn is sampled only at the start edge and at each carrier bottom. A change at any other time first takes effect in the next triangle.
- R5: dutyIn is sampled only at the start edge and at each carrier bottom. A change at any other time has no effect on the current triangle.
- R6: With duty D, where 2 <= D <= P, dutyPulse is high for one cycle after edge D-1 of each triangle with slopeDown 0, and after edge 2P-D+1 with slopeDown 1.
- R7: With D = P+1, one pulse occurs per triangle, at the peak, with slopeDown 0. With D = 1, a pulse occurs at the start edge with slopeDown 0 and at each later bottom with slopeDown 1. With D = 0 or D > P+1, no pulse occurs.
- R8: slopeDown changes only in a cycle where dutyPulse is 1, and holds its value between pulses.
- R9: A start edge while the channel is already running is ignored. The carrier and duty schedule continue unchanged.
- R10: While runEn is 0, the channel stops, goes idle and emits no pulses. Start is ignored while runEn is 0. After runEn returns to 1, the channel stays idle until a new start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| runEn | input | 1 | Channel enable; 0 stops and idles the channel |
| start | input | 1 | Start request; acts only when idle and enabled |
| periodIn | input | WIDTH | Carrier peak value P |
| dutyIn | input | WIDTH | Duty compare value D |
| dutyPulse | output | 1 | One-cycle pulse when the duty tracker reaches one |
| slopeDown | output | 1 | 1 if the latest duty pulse fell on the falling half |
| periodPulse | output | 1 | One-cycle pulse at the carrier bottom |
| dirDown | output | 1 | 1 while the carrier is on its falling half |

## Verification
Every output is a register, so each result appears in the cycle right after the clock edge that causes it. The start edge is edge 0. After edge k the carrier holds its count k (modulo the triangle), and the pulses and dirDown reflect that same edge. The bench drives inputs and samples outputs at falling clock edges. It indexes each sample by the number of rising edges since start and compares every output against the schedule that R2, R3, R6 and R7 give for that index. Mid-triangle changes to period and duty, a repeated start and loss of enable are placed at known indices, so the expected switch-over edge is exact.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

  // Strobes passed from the carrier control to the duty datapath each cycle.
  typedef struct packed {
    logic load;      // channel start: load duty, carrier at bottom
    logic reload;    // carrier bottom reached on a falling step
    logic stepUp;    // carrier rises this cycle (tracker falls)
    logic stepDown;  // carrier falls this cycle (tracker rises)
  } strobe_t;

endpackage

// File: rtl/tri_pwm_carrier_ctrl.sv
module tri_pwm_carrier_ctrl
  import tri_pwm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             runEn,
  input  logic             start,
  input  logic [WIDTH-1:0] periodIn,
  output strobe_t          strobes,
  output logic             periodPulse,
  output logic             dirDown
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic             active;
  logic [WIDTH-1:0] carrierCnt;
  logic [WIDTH-1:0] periodReg;
  logic [WIDTH-1:0] periodSafe;
  logic [WIDTH-1:0] carrierInc;

  assign periodSafe = (periodIn == ZERO) ? ONE : periodIn;
  assign carrierInc = carrierCnt + ONE;

  always_comb begin
    strobes          = '0;
    strobes.load     = start && runEn && !active;
    strobes.stepUp   = active && runEn && !dirDown;
    strobes.stepDown = active && runEn && dirDown;
    strobes.reload   = active && runEn && dirDown && (carrierCnt == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      carrierCnt  <= ZERO;
      periodReg   <= ZERO;
      periodPulse <= 1'b0;
      dirDown     <= 1'b0;
    end else begin
      periodPulse <= 1'b0;
      if (!runEn) begin
        active <= 1'b0;
      end else if (strobes.load) begin
        active     <= 1'b1;
        carrierCnt <= ZERO;
        dirDown    <= 1'b0;
        periodReg  <= periodSafe;
      end else if (strobes.stepUp) begin
        carrierCnt <= carrierInc;
        if (carrierInc >= periodReg) begin
          dirDown <= 1'b1;
        end
      end else if (strobes.stepDown) begin
        carrierCnt <= carrierCnt - ONE;
        if (strobes.reload) begin
          dirDown     <= 1'b0;
          periodPulse <= 1'b1;
          periodReg   <= periodSafe;
        end
      end
    end
  end

endmodule

// File: rtl/tri_pwm_duty_path.sv
module tri_pwm_duty_path
  import tri_pwm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] dutyIn,
  output logic             dutyPulse,
  output logic             slopeDown
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] trackCnt;
  logic [WIDTH-1:0] trackNext;
  logic             moved;
  logic             hitOne;

  always_comb begin
    trackNext = trackCnt;
    moved     = 1'b0;
    if (strobes.load || strobes.reload) begin
      trackNext = dutyIn;
      moved     = 1'b1;
    end else if (strobes.stepUp) begin
      trackNext = trackCnt - ONE;
      moved     = 1'b1;
    end else if (strobes.stepDown) begin
      trackNext = trackCnt + ONE;
      moved     = 1'b1;
    end
  end

  assign hitOne = moved && (trackNext == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      trackCnt  <= '0;
      dutyPulse <= 1'b0;
      slopeDown <= 1'b0;
    end else begin
      trackCnt  <= trackNext;
      dutyPulse <= hitOne;
      if (hitOne) begin
        slopeDown <= strobes.stepDown;
      end
    end
  end

endmodule

// File: rtl/tri_pwm_duty.sv
module tri_pwm_duty
  import tri_pwm_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             runEn,
  input  logic             start,
  input  logic [WIDTH-1:0] periodIn,
  input  logic [WIDTH-1:0] dutyIn,
  output logic             dutyPulse,
  output logic             slopeDown,
  output logic             periodPulse,
  output logic             dirDown
);

  strobe_t strobes;

  tri_pwm_carrier_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .runEn      (runEn),
    .start      (start),
    .periodIn   (periodIn),
    .strobes    (strobes),
    .periodPulse(periodPulse),
    .dirDown    (dirDown)
  );

  tri_pwm_duty_path #(.WIDTH(WIDTH)) u_path (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .dutyIn   (dutyIn),
    .dutyPulse(dutyPulse),
    .slopeDown(slopeDown)
  );

endmodule

// File: rtl/tri_pwm_duty_chk.sv
module tri_pwm_duty_chk (
  input logic clk,
  input logic rst,
  input logic runEn,
  input logic dutyPulse,
  input logic slopeDown,
  input logic periodPulse,
  input logic dirDown
);

  p_bottom_rising_r3: assert property (@(posedge clk) disable iff (rst)
    periodPulse |-> !dirDown);

  p_single_period_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    periodPulse |=> !periodPulse);

  p_bottom_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
    periodPulse |-> $past(dirDown));

  p_down_pulse_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (dutyPulse && slopeDown) |-> (dirDown || periodPulse));

  p_slope_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !dutyPulse |-> $stable(slopeDown));

  p_stop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !runEn |=> (!dutyPulse && !periodPulse));

endmodule

bind tri_pwm_duty tri_pwm_duty_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .runEn      (runEn),
  .dutyPulse  (dutyPulse),
  .slopeDown  (slopeDown),
  .periodPulse(periodPulse),
  .dirDown    (dirDown)
);

// File: tb/tri_pwm_duty_tb.sv
module tri_pwm_duty_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NVEC = 11;
  // columns: periodIn, effective P, duty, rising-half offset, falling-half offset (0 = none)
  localparam int VEC [NVEC][5] = '{
    '{4, 4, 2, 1, 7},
    '{4, 4, 3, 2, 6},
    '{4, 4, 4, 3, 5},
    '{4, 4, 5, 4, 0},
    '{4, 4, 1, 0, 8},
    '{4, 4, 0, 0, 0},
    '{4, 4, 9, 0, 0},
    '{1, 1, 1, 0, 2},
    '{1, 1, 2, 1, 0},
    '{6, 6, 3, 2, 10},
    '{0, 1, 2, 1, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic runEn = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] periodIn = '0;
  logic [W-1:0] dutyIn = '0;
  logic dutyPulse, slopeDown, periodPulse, dirDown;

  int nChecks = 0;
  int nFails = 0;

  tri_pwm_duty #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .runEn(runEn), .start(start),
    .periodIn(periodIn), .dutyIn(dutyIn),
    .dutyPulse(dutyPulse), .slopeDown(slopeDown),
    .periodPulse(periodPulse), .dirDown(dirDown)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic checkIdleOutputs(input string req);
    chk(dutyPulse == 1'b0, req, dutyPulse, 0);
    chk(slopeDown == 1'b0, req, slopeDown, 0);
    chk(periodPulse == 1'b0, req, periodPulse, 0);
    chk(dirDown == 1'b0, req, dirDown, 0);
  endtask

  // Leaves the bench at the falling edge after the start edge (index 0).
  task automatic startCh();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runSched(input int effP, input int duty, input int up, input int dn,
                          input int nCyc, input int restartAt);
    int m;
    bit eD, eP, eR;
    int eS;
    eS = 0;
    for (int k = 0; k <= nCyc; k++) begin
      m  = (k == 0) ? 0 : ((k - 1) % (2 * effP)) + 1;
      eD = (k == 0) ? (duty == 1) : (m == up || m == dn);
      if (eD) eS = (k != 0 && m == dn) ? 1 : 0;
      eP = (k >= 1) && (m == 2 * effP);
      eR = (k >= 1) && (m >= effP) && (m < 2 * effP);
      chk(dutyPulse == eD, "R6/R7 duty pulse", dutyPulse, eD);
      chk(slopeDown == eS[0], "R8 slope flag", slopeDown, eS);
      chk(periodPulse == eP, "R3 period pulse", periodPulse, eP);
      chk(dirDown == eR, "R2 direction", dirDown, eR);
      start = (k == restartAt);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    checkIdleOutputs("R1 reset state");

    // table walk: R6 R7 schedules plus R2 R3 R8 every cycle
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      runEn = 1'b1;
      periodIn = W'(VEC[v][0]);
      dutyIn = W'(VEC[v][2]);
      @(negedge clk);
      startCh();
      runSched(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 6 * VEC[v][1] + 2, -1);
    end

    // R9: repeated start mid-run is ignored
    doReset();
    runEn = 1'b1; periodIn = W'(4); dutyIn = W'(2);
    @(negedge clk);
    startCh();
    runSched(4, 2, 1, 7, 20, 3);

    // R4 R5: new period and duty written mid-triangle apply from the next bottom
    doReset();
    runEn = 1'b1; periodIn = W'(4); dutyIn = W'(2);
    @(negedge clk);
    startCh();
    for (int k = 0; k <= 13; k++) begin
      bit eD, eP;
      eD = (k == 1 || k == 7 || k == 10);
      eP = (k == 8 || k == 12);
      chk(dutyPulse == eD, "R5 duty latched per triangle", dutyPulse, eD);
      chk(periodPulse == eP, "R4 period latched per triangle", periodPulse, eP);
      if (eD) chk(slopeDown == (k == 7), "R5 slope", slopeDown, (k == 7));
      if (k == 2) begin periodIn = W'(2); dutyIn = W'(3); end
      @(negedge clk);
    end

    // R10: drop enable, re-enable without start stays idle, start ignored while disabled
    doReset();
    runEn = 1'b1; periodIn = W'(4); dutyIn = W'(2);
    @(negedge clk);
    startCh();
    for (int k = 0; k <= 20; k++) begin
      if (k >= 3) begin
        chk(dutyPulse == 1'b0, "R10 no duty pulse when stopped", dutyPulse, 0);
        chk(periodPulse == 1'b0, "R10 no period pulse when stopped", periodPulse, 0);
      end
      if (k == 2) runEn = 1'b0;
      start = (k == 5);
      if (k == 8) runEn = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    startCh();
    runSched(4, 2, 1, 7, 16, -1);

    // R1: reset in the middle of a falling half
    doReset();
    runEn = 1'b1; periodIn = W'(4); dutyIn = W'(2);
    @(negedge clk);
    startCh();
    for (int k = 0; k < 5; k++) @(negedge clk);
    chk(dirDown == 1'b1, "R2 falling half before reset", dirDown, 1);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    checkIdleOutputs("R1 reset mid-run");
    rst = 1'b0;
    @(negedge clk);
    checkIdleOutputs("R1 idle after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule